// File: doc/BRIEF.md
# Four-Lane Receive Frame-End Checker

This block checks the end of each received frame on a four-lane receive path where the lanes are already aligned into columns. Each accepted input beat is one column. For each lane the column gives a decoded code-group kind, an 8-bit value and a flag that marks a running-disparity error. The block finds the terminate code-group, looks one column behind it and one column ahead of it, and replaces data bytes that cannot be trusted with the error control character. It turns the idle-class code-groups (K, A, R) into the plain idle control character. The result is a per-lane byte plus control flag for each column.

The block keeps a window of three columns. The column that leaves on a given accepted beat is the one accepted two beats earlier. Both edges of the block are valid/ready streams. An input beat is taken only when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being read in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and no input is taken. The window moves only when input arrives, so the last two columns of a burst stay inside the block until more columns follow.

Kind encoding on `in_kind` (3 bits per lane, lane i at bits 3i+2..3i): 0 data, 1 K, 2 A, 3 R, 4 terminate, 5 start, 6 other. Output bytes with the control flag set: idle 0x07, terminate 0xFD, start 0xFB, error 0xFE. Lane i uses bits 8i+7..8i of the data buses and bit i of the flag buses.

Top module: `rx_term_chk`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0, `in_ready` is 1, and every output lane shows idle (0x07, control 1). Output stays invalid until three columns have been accepted.
- R2: The column accepted on beat k comes out on the beat on which column k+2 is accepted. A data lane (kind 0) that no rule marks passes its byte unchanged with control 0.
- R3: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While stalled in this way, `out_data`, `out_ctrl` and `out_valid` hold their values.
- R4: The lowest-index lane holding a terminate (kind 4) in a column comes out as 0xFD with control 1.
- R5: Every lane with an index below the terminate lane n comes out as 0xFE if any lane of the following column has a disparity error or a kind other than K or A. When the parameter PER_LANE_AHEAD is 1, each lane instead checks only its own lane of the following column.
- R6: When the following column holds its terminate in lane n, each data lane above n in the current column comes out as 0xFE if the same lane of the terminate column has a disparity error or a kind other than K. Other lanes are not affected.
- R7: K, A and R code-groups come out as idle 0x07 with control 1. This covers the lanes above the terminate in its own column and the idle columns that follow.
- R8: In the column right after a terminate column, a K, A or R lane with a disparity error comes out as 0xFE. The other lanes of that column stay idle.
- R9: When a column holds more than one terminate, only the lowest one is output as terminate. Every higher lane that is not K, A or R, including the extra terminates, comes out as 0xFE.
- R10: A start code-group (kind 5) comes out as 0xFB with control 1. A kind 6 code-group comes out as 0xFE with control 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input column present |
| in_ready | output | 1 | Block can take a column this cycle |
| in_kind | input | 12 | Per-lane code-group kind, 3 bits per lane |
| in_val | input | 32 | Per-lane decoded byte |
| in_derr | input | 4 | Per-lane running-disparity error flag |
| out_valid | output | 1 | Output column present |
| out_ready | input | 1 | Consumer takes the output column |
| out_data | output | 32 | Per-lane output byte |
| out_ctrl | output | 4 | Per-lane control flag |

## Verification
A wrong terminate-lane index, or a stale after-terminate flag, shows up at the ports as an error byte or a missing error byte. It appears in the column that leaves two accepted beats after the affected column entered, or in the column next to it. A window that shifts wrongly or a fill count that is off shows up as a column out of order, or as a valid output one beat early or late, on the first output after reset. A handshake fault shows up during stalls as an output that changes while it is being held, or as a column that is lost or duplicated in the scoreboard order.

// File: rtl/rx_term_pkg.sv
package rx_term_pkg;

  typedef enum logic [2:0] {
    CG_DATA  = 3'd0,
    CG_K     = 3'd1,
    CG_A     = 3'd2,
    CG_R     = 3'd3,
    CG_TERM  = 3'd4,
    CG_START = 3'd5,
    CG_OTHER = 3'd6
  } cg_kind_e;

  typedef struct packed {
    cg_kind_e   kind;
    logic [7:0] val;
    logic       derr;
  } cg_lane_t;

  localparam logic [7:0] XG_IDLE  = 8'h07;
  localparam logic [7:0] XG_TERM  = 8'hFD;
  localparam logic [7:0] XG_ERR   = 8'hFE;
  localparam logic [7:0] XG_START = 8'hFB;

endpackage

// File: rtl/rx_term_find.sv
// Finds the lowest lane holding a terminate in one column.
module rx_term_find #(
  parameter int LANES = 4,
  parameter int IW    = 2
) (
  input  logic [LANES-1:0] hit,
  output logic             found,
  output logic [IW-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rx_term_ahead.sv
// Judges whether the column after a terminate is clean, whole-column or per lane.
module rx_term_ahead
  import rx_term_pkg::*;
#(
  parameter int LANES    = 4,
  parameter bit PER_LANE = 1'b0
) (
  input  cg_kind_e         nxt_kind [LANES],
  input  logic [LANES-1:0] nxt_derr,
  output logic [LANES-1:0] bad
);
  logic [LANES-1:0] lane_bad;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bad[g] = nxt_derr[g] ||
                         !(nxt_kind[g] == CG_K || nxt_kind[g] == CG_A);
  end

  if (PER_LANE) begin : g_per
    assign bad = lane_bad;
  end else begin : g_whole
    assign bad = {LANES{|lane_bad}};
  end
endmodule

// File: rtl/rx_term_lane.sv
// Output decode of one lane, applying the frame-end marking rules.
module rx_term_lane
  import rx_term_pkg::*;
#(
  parameter int LANE = 0,
  parameter int IW   = 2
) (
  input  cg_lane_t      cur,
  input  cg_kind_e      nxt_kind,
  input  logic          nxt_derr,
  input  logic          cur_t_found,
  input  logic [IW-1:0] cur_t_idx,
  input  logic          nxt_t_found,
  input  logic [IW-1:0] nxt_t_idx,
  input  logic          ahead_bad,
  input  logic          after_t,
  output logic [7:0]    o_data,
  output logic          o_ctrl
);
  localparam logic [IW-1:0] MY = IW'(LANE);

  logic is_idle_cls;
  assign is_idle_cls = (cur.kind == CG_K) || (cur.kind == CG_A) || (cur.kind == CG_R);

  always_comb begin
    o_ctrl = 1'b1;
    unique case (cur.kind)
      CG_DATA:             begin o_data = cur.val; o_ctrl = 1'b0; end
      CG_K, CG_A, CG_R:    o_data = XG_IDLE;
      CG_TERM:             o_data = XG_TERM;
      CG_START:            o_data = XG_START;
      default:             o_data = XG_ERR;
    endcase

    if (cur_t_found && cur_t_idx == MY) begin
      o_data = XG_TERM;
      o_ctrl = 1'b1;
    end else if (cur_t_found && cur_t_idx < MY) begin
      o_ctrl = 1'b1;
      o_data = (is_idle_cls && !(after_t && cur.derr)) ? XG_IDLE : XG_ERR;
    end else if (cur_t_found && cur_t_idx > MY && ahead_bad) begin
      o_data = XG_ERR;
      o_ctrl = 1'b1;
    end else if (nxt_t_found && nxt_t_idx < MY && cur.kind == CG_DATA &&
                 (nxt_derr || nxt_kind != CG_K)) begin
      o_data = XG_ERR;
      o_ctrl = 1'b1;
    end else if (after_t && is_idle_cls && cur.derr) begin
      o_data = XG_ERR;
      o_ctrl = 1'b1;
    end
  end
endmodule

// File: rtl/rx_term_chk.sv
module rx_term_chk
  import rx_term_pkg::*;
#(
  parameter int LANES          = 4,
  parameter bit PER_LANE_AHEAD = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LANES*3-1:0] in_kind,
  input  logic [LANES*8-1:0] in_val,
  input  logic [LANES-1:0]   in_derr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [LANES*8-1:0] out_data,
  output logic [LANES-1:0]   out_ctrl
);
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;

  cg_lane_t in_col [LANES];
  cg_lane_t cur_q  [LANES];
  cg_lane_t nxt_q  [LANES];
  cg_kind_e         nxt_kind [LANES];
  logic [LANES-1:0] nxt_derr;
  logic [LANES-1:0] cur_hit, nxt_hit, ahead_bad;
  logic             cur_t_found, nxt_t_found;
  logic [IW-1:0]    cur_t_idx, nxt_t_idx;
  logic [7:0]       ln_data [LANES];
  logic [LANES-1:0] ln_ctrl;
  logic [LANES*8-1:0] col_data;
  logic             after_t_q;
  logic [1:0]       fill_q;
  logic             out_valid_q;
  logic [LANES*8-1:0] out_data_q;
  logic [LANES-1:0]   out_ctrl_q;
  logic             adv;

  assign in_ready = out_ready || !out_valid_q;
  assign adv      = in_valid && in_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_col
    assign in_col[g]   = '{kind: cg_kind_e'(in_kind[g*3 +: 3]),
                           val:  in_val[g*8 +: 8],
                           derr: in_derr[g]};
    assign nxt_kind[g] = nxt_q[g].kind;
    assign nxt_derr[g] = nxt_q[g].derr;
    assign cur_hit[g]  = (cur_q[g].kind == CG_TERM);
    assign nxt_hit[g]  = (nxt_q[g].kind == CG_TERM);
    assign col_data[g*8 +: 8] = ln_data[g];

    rx_term_lane #(.LANE(g), .IW(IW)) u_lane (
      .cur         (cur_q[g]),
      .nxt_kind    (nxt_q[g].kind),
      .nxt_derr    (nxt_q[g].derr),
      .cur_t_found (cur_t_found),
      .cur_t_idx   (cur_t_idx),
      .nxt_t_found (nxt_t_found),
      .nxt_t_idx   (nxt_t_idx),
      .ahead_bad   (ahead_bad[g]),
      .after_t     (after_t_q),
      .o_data      (ln_data[g]),
      .o_ctrl      (ln_ctrl[g])
    );
  end

  rx_term_find #(.LANES(LANES), .IW(IW)) u_find_cur (
    .hit(cur_hit), .found(cur_t_found), .idx(cur_t_idx));
  rx_term_find #(.LANES(LANES), .IW(IW)) u_find_nxt (
    .hit(nxt_hit), .found(nxt_t_found), .idx(nxt_t_idx));

  rx_term_ahead #(.LANES(LANES), .PER_LANE(PER_LANE_AHEAD)) u_ahead (
    .nxt_kind(nxt_kind), .nxt_derr(nxt_derr), .bad(ahead_bad));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LANES; i++) begin
        cur_q[i] <= '{kind: CG_K, val: 8'h00, derr: 1'b0};
        nxt_q[i] <= '{kind: CG_K, val: 8'h00, derr: 1'b0};
      end
      after_t_q   <= 1'b0;
      fill_q      <= 2'd0;
      out_valid_q <= 1'b0;
      out_data_q  <= {LANES{XG_IDLE}};
      out_ctrl_q  <= '1;
    end else if (adv) begin
      nxt_q     <= in_col;
      cur_q     <= nxt_q;
      after_t_q <= cur_t_found;
      if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
      out_valid_q <= (fill_q == 2'd2);
      if (fill_q == 2'd2) begin
        out_data_q <= col_data;
        out_ctrl_q <= ln_ctrl;
      end
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign out_ctrl  = out_ctrl_q;

  // R1: reset empties the output
  a_r1_reset_empty: assert property (@(posedge clk) rst |=> !out_valid);

  // R3: a stalled output holds still
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl)));

  // R3: a stalled output blocks input
  a_r3_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: at most one terminate byte leaves per column
  logic [LANES-1:0] term_out;
  for (genvar g = 0; g < LANES; g++) begin : g_tchk
    assign term_out[g] = out_ctrl[g] && (out_data[g*8 +: 8] == XG_TERM);
  end
  a_r9_one_term: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0(term_out));

  // R5: lane 0 lies below any terminate above it and is marked when ahead is bad
  a_r5_low_lane_marked: assert property (@(posedge clk) disable iff (rst)
    (adv && fill_q == 2'd2 && cur_t_found && cur_t_idx != '0 && ahead_bad[0])
    |=> (out_ctrl[0] && out_data[7:0] == XG_ERR));

  // R8: disparity error on an idle lane just after a terminate column
  for (genvar g = 0; g < LANES; g++) begin : g_r8
    a_r8_after_err: assert property (@(posedge clk) disable iff (rst)
      (adv && fill_q == 2'd2 && after_t_q && !cur_t_found && !nxt_t_found &&
       cur_q[g].kind == CG_A && cur_q[g].derr)
      |=> (out_ctrl[g] && out_data[g*8 +: 8] == XG_ERR));
  end
endmodule

// File: tb/rx_term_chk_tb_top.sv
module rx_term_chk_tb_top;
  import rx_term_pkg::*;

  localparam int D = 0, K = 1, A = 2, R = 3, T = 4, S = 5, O = 6;
  localparam bit PER = 1'b0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_kind = '0;
  logic [31:0] in_val = '0;
  logic [3:0]  in_derr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [3:0]  out_ctrl;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit stall_en = 0;
  logic [7:0] lfsr = 8'hA5;

  logic [31:0] exp_d [$];
  logic [3:0]  exp_c [$];
  string       exp_tag [$];

  bit          have_prev = 0;
  bit          pp_t = 0;
  logic [11:0] pk;
  logic [31:0] pv;
  logic [3:0]  pd;
  string       ptag;

  always #2.5 clk = ~clk;

  rx_term_chk dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_val(in_val), .in_derr(in_derr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ctrl(out_ctrl));

  function automatic logic [11:0] kc(int k0, int k1, int k2, int k3);
    return {3'(k3), 3'(k2), 3'(k1), 3'(k0)};
  endfunction

  function automatic bit is_idle(int k);
    return (k == K) || (k == A) || (k == R);
  endfunction

  // Reference model built from the requirements: returns {data, ctrl}
  function automatic logic [35:0] model(bit pt, logic [11:0] ck, logic [31:0] cv,
                                        logic [3:0] cd, logic [11:0] nk, logic [3:0] nd);
    logic [31:0] od;
    logic [3:0]  oc;
    int tc, tn;
    bit anybad;
    bit lb [4];
    int ci, ni;
    tc = -1; tn = -1; anybad = 0;
    for (int i = 0; i < 4; i++) begin
      ci = int'(ck[i*3 +: 3]);
      ni = int'(nk[i*3 +: 3]);
      oc[i] = 1'b1;
      case (ci)
        D: begin od[i*8 +: 8] = cv[i*8 +: 8]; oc[i] = 1'b0; end
        K, A, R: od[i*8 +: 8] = 8'h07;
        T: od[i*8 +: 8] = 8'hFD;
        S: od[i*8 +: 8] = 8'hFB;
        default: od[i*8 +: 8] = 8'hFE;
      endcase
      if (ci == T && tc < 0) tc = i;
      if (ni == T && tn < 0) tn = i;
      lb[i] = nd[i] || !(ni == K || ni == A);
      anybad |= lb[i];
    end
    for (int i = 0; i < 4; i++)
      if (pt && is_idle(int'(ck[i*3 +: 3])) && cd[i]) begin
        od[i*8 +: 8] = 8'hFE; oc[i] = 1'b1;
      end
    if (tn >= 0)
      for (int i = tn + 1; i < 4; i++)
        if (int'(ck[i*3 +: 3]) == D && (nd[i] || int'(nk[i*3 +: 3]) != K)) begin
          od[i*8 +: 8] = 8'hFE; oc[i] = 1'b1;
        end
    if (tc >= 0)
      for (int i = 0; i < 4; i++) begin
        if (i < tc) begin
          if (PER ? lb[i] : anybad) begin od[i*8 +: 8] = 8'hFE; oc[i] = 1'b1; end
        end else if (i == tc) begin
          od[i*8 +: 8] = 8'hFD; oc[i] = 1'b1;
        end else begin
          oc[i] = 1'b1;
          od[i*8 +: 8] = (is_idle(int'(ck[i*3 +: 3])) && !(pt && cd[i])) ? 8'h07 : 8'hFE;
        end
      end
    return {od, oc};
  endfunction

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Driver: hands one column to the DUT and queues the expectation of the one before it
  task automatic send(logic [11:0] k, logic [31:0] v, logic [3:0] d, string tag);
    bit acc;
    logic [35:0] e;
    bit has_t;
    in_kind = k; in_val = v; in_derr = d; in_valid = 1'b1;
    do begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
    end while (!acc);
    #1;
    if (have_prev) begin
      e = model(pp_t, pk, pv, pd, k, d);
      exp_d.push_back(e[35:4]);
      exp_c.push_back(e[3:0]);
      exp_tag.push_back(ptag);
    end
    has_t = 0;
    if (have_prev)
      for (int i = 0; i < 4; i++) if (int'(pk[i*3 +: 3]) == T) has_t = 1;
    pp_t = has_t;
    pk = k; pv = v; pd = d; ptag = tag; have_prev = 1;
  endtask

  task automatic idle_cols(int n);
    for (int i = 0; i < n; i++) send(kc(K, R, A, K), 32'h0, 4'h0, "R7");
  endtask

  task automatic frame_head(logic [7:0] seed);
    send(kc(S, D, D, D), {seed, seed + 8'd1, seed + 8'd2, 8'h00}, 4'h0, "R10");
    send(kc(D, D, D, D), {seed ^ 8'h3C, seed + 8'd7, seed ^ 8'hFE, seed + 8'd9}, 4'h0, "R2");
  endtask

  // Monitor: pops the scoreboard on every output transfer
  logic [31:0] hold_d;
  logic [3:0]  hold_c;
  bit          hold_pend = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        total++;
        if (!out_valid || out_data !== hold_d || out_ctrl !== hold_c) begin
          bad++;
          $display("FAIL R3 stall hold: got v=%0b %h/%h exp v=1 %h/%h",
                   out_valid, out_data, out_ctrl, hold_d, hold_c);
        end
      end
      hold_pend = out_valid && !out_ready;
      hold_d = out_data; hold_c = out_ctrl;
      if (out_valid && out_ready) begin
        total++;
        if (exp_d.size() == 0) begin
          bad++;
          $display("FAIL R2 unexpected column: got %h/%h exp none", out_data, out_ctrl);
        end else begin
          logic [31:0] ed;
          logic [3:0]  ec;
          string       et;
          ed = exp_d.pop_front(); ec = exp_c.pop_front(); et = exp_tag.pop_front();
          if (out_data !== ed || out_ctrl !== ec) begin
            bad++;
            $display("FAIL %s column: got %h/%h exp %h/%h", et, out_data, out_ctrl, ed, ec);
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  task automatic scenarios(logic [7:0] seed);
    idle_cols(3);
    // R4 terminate at every lane position, clean idle after
    for (int n = 0; n < 4; n++) begin
      logic [11:0] tk;
      frame_head(seed + 8'(n * 16));
      tk = '0;
      for (int i = 0; i < 4; i++) tk[i*3 +: 3] = (i < n) ? 3'(D) : (i == n) ? 3'(T) : 3'(K);
      send(tk, {8'h44, 8'h33, 8'h22, 8'h11} ^ {4{seed}}, 4'h0, "R4");
      send(kc(A, A, A, A), 32'h0, 4'h0, "R7");
      idle_cols(1);
    end
    // R5 whole-column look-ahead with a disparity error on A in lane 0; R8 on that lane
    frame_head(seed + 8'h50);
    send(kc(D, D, D, T), 32'h00C0B0A0, 4'h0, "R5");
    send(kc(A, A, A, A), 32'h0, 4'h1, "R8");
    idle_cols(1);
    // R5 with /R/ in the following column
    frame_head(seed + 8'h60);
    send(kc(D, D, T, K), 32'h0000B1A1, 4'h0, "R5");
    send(kc(R, R, R, R), 32'h0, 4'h0, "R7");
    idle_cols(1);
    // R5 with data in the following column
    frame_head(seed + 8'h70);
    send(kc(D, T, K, K), 32'h000000A2, 4'h0, "R5");
    send(kc(D, D, A, A), 32'h00001234, 4'h0, "R2");
    idle_cols(1);
    // R6 look-behind: lane 2 holds A, lane 3 has a K with disparity error
    frame_head(seed + 8'h80);
    send(kc(D, D, D, D), 32'h91827364, 4'h0, "R6");
    send(kc(D, T, A, K), 32'h000000A3, 4'h8, "R6");
    idle_cols(2);
    // R9 two terminates in one column
    frame_head(seed + 8'h90);
    send(kc(D, T, T, K), 32'h000000A4, 4'h0, "R9");
    idle_cols(2);
    // R10 other kind inside data
    frame_head(seed + 8'hA0);
    send(kc(D, O, D, D), 32'h55667788, 4'h0, "R10");
    send(kc(T, K, K, K), 32'h0, 4'h0, "R4");
    idle_cols(2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1 || out_data !== 32'h07070707 || out_ctrl !== 4'hF) begin
      bad++;
      $display("FAIL R1 reset: got v=%0b r=%0b %h/%h exp v=0 r=1 07070707/f",
               out_valid, in_ready, out_data, out_ctrl);
    end
    @(posedge clk); #1;
    scenarios(8'h10);
    stall_en = 1;
    scenarios(8'h21);
    stall_en = 0;
    in_valid = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    total++;
    if (exp_d.size() != 1) begin
      bad++;
      $display("FAIL R2 queue left: got %0d exp 1", exp_d.size());
    end
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got running exp finished");
    finish_up();
  end
endmodule